// File: doc/BRIEF.md
# Eight-by-four residual reconstruction unit

This unit rebuilds a 4-row by 8-column block of pixels from its transform coefficients and a prediction. Four rows of eight signed 16-bit coefficients are loaded one row per cycle. A sequenced datapath then runs an eight-point inverse transform across each of the four rows and a four-point inverse transform down each of the eight columns. Both passes reuse one in-place buffer. The residual that results is added to the predicted pixels, one 8-pixel row per cycle, through a pixel row port. On that port the unit names a row, takes the predicted row in the same cycle and returns the reconstructed row, which the caller writes back to that row.

A state machine with six states controls the work:
- `ST_IDLE` waits for the first coefficient row.
- `ST_LOAD` collects the remaining rows.
- `ST_ROW` runs one row transform per cycle.
- `ST_COL` runs one column transform per cycle.
- `ST_ADD` emits one reconstructed row per cycle.
- `ST_DONE` raises the completion pulse.

The transitions are:
- IDLE→LOAD on the first accepted row.
- LOAD→ROW on the fourth accepted row.
- ROW→COL after four cycles.
- COL→ADD after eight cycles.
- ADD→DONE after four cycles.
- DONE→IDLE unconditionally.

Top module: `rr8x4_recon`

## Requirements
- R1: Each row is transformed with the eight-point kernel, rounding constant 4 and arithmetic right shift by 3. Write the row inputs as c0..c7. The kernel forms an even part from 12(c0±c4)+4, 16c2+6c6 and 6c2−16c6. It forms an odd part with the weights (16,15,9,4), (15,−4,−16,−9), (9,−16,4,15) and (4,−9,15,−16) on c1,c3,c5,c7. Output k and output 7−k are the even term k plus and minus the odd term k.
- R2: Row-pass results are truncated (wrapped) to 16-bit signed values before the column pass.
- R3: Each column is transformed with the four-point kernel, rounding constant 64 and arithmetic right shift by 7. For column inputs r0..r3 the four outputs are:
  - row 0: 17r0+17r2+22r1+10r3+64;
  - row 1: 17r0−17r2+10r1−22r3+64;
  - row 2: 17r0−17r2−10r1+22r3+64;
  - row 3: 17r0+17r2−22r1−10r3+64.
  Each is shifted, and the result is truncated to 16-bit signed.
- R4: Each residual is added to its prediction pixel, zero-extended, with a 16-bit signed saturating addition.
- R5: The saturated sum is clamped to 0..255 to form the output pixel.
- R6: Exactly four reconstructed rows are produced, on consecutive cycles with `pix_en` high, and `pix_row` goes 0,1,2,3. Lane k of `pred_pix` and `recon_pix` is bits [8k+7:8k].
- R7: `done` is high for exactly one cycle, the cycle right after the last reconstructed row.
- R8: `coef_valid` is ignored from the fourth accepted row until the unit is back in `ST_IDLE`. The current result is unchanged and the next block loads normally.
- R9: Out of reset `pix_en` and `done` are low.
- R10: Coefficient rows are stored in arrival order as rows 0..3, with idle gaps allowed. Lane k of `coef_row` is bits [16k+15:16k]. The first reconstructed row appears 12 clock edges after the edge that accepts row 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_valid | input | 1 | Coefficient row present on `coef_row` |
| coef_row | input | 128 | Eight signed 16-bit coefficients, lane k at [16k+15:16k] |
| pix_en | output | 1 | Pixel row access active this cycle |
| pix_row | output | 2 | Index of the pixel row being read and written |
| pred_pix | input | 64 | Predicted row for `pix_row`, eight unsigned 8-bit lanes |
| recon_pix | output | 64 | Reconstructed row for `pix_row` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench attacks the places where a plausible design goes wrong:
- Full-range random coefficients overflow 16 bits after the row pass. A design that keeps the wide intermediate, or that saturates it instead of wrapping, then produces different pixels.
- Large positive and negative DC blocks over extreme predictions test the clamp. A missing or misplaced clamp wraps a bright pixel to near black, or a dark pixel to near white.
- Coefficient rows arrive with idle gaps, and garbage rows keep arriving while the block is busy. A counter that advances on idle cycles, or that accepts rows during processing, corrupts the block or shifts the output latency.
- The row order, the exact first-row cycle and the single-cycle completion pulse are checked against cycle counts.

// File: rtl/rr8x4_pkg.sv
package rr8x4_pkg;

    localparam int ROWS   = 4;
    localparam int COLS   = 8;
    localparam int ROW_IW = $clog2(ROWS);
    localparam int CNT_W  = $clog2(COLS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ROW,
        ST_COL,
        ST_ADD,
        ST_DONE
    } rr_state_e;

endpackage

// File: rtl/rr8x4_row8.sv
// Eight-point inverse transform applied across one row.
module rr8x4_row8 #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 32,
    parameter int OUT_W = 16,
    parameter int RND   = 4,
    parameter int SHIFT = 3
) (
    input  logic signed [IN_W-1:0]  x [8],
    output logic signed [OUT_W-1:0] y [8]
);
    localparam logic signed [ACC_W-1:0] K4   = ACC_W'(4);
    localparam logic signed [ACC_W-1:0] K6   = ACC_W'(6);
    localparam logic signed [ACC_W-1:0] K9   = ACC_W'(9);
    localparam logic signed [ACC_W-1:0] K12  = ACC_W'(12);
    localparam logic signed [ACC_W-1:0] K15  = ACC_W'(15);
    localparam logic signed [ACC_W-1:0] K16  = ACC_W'(16);
    localparam logic signed [ACC_W-1:0] RNDC = ACC_W'(RND);

    logic signed [ACC_W-1:0] e [8];

    for (genvar k = 0; k < 8; k++) begin : g_ext
        assign e[k] = ACC_W'(x[k]);
    end

    logic signed [ACC_W-1:0] ev0, ev1, ev2, ev3;
    logic signed [ACC_W-1:0] a0, a1, a2, a3;
    logic signed [ACC_W-1:0] o0, o1, o2, o3;

    always_comb begin
        ev0 = K12 * (e[0] + e[4]) + RNDC;
        ev1 = K12 * (e[0] - e[4]) + RNDC;
        ev2 = K16 * e[2] + K6 * e[6];
        ev3 = K6 * e[2] - K16 * e[6];
        a0  = ev0 + ev2;
        a1  = ev1 + ev3;
        a2  = ev1 - ev3;
        a3  = ev0 - ev2;
        o0  = K16 * e[1] + K15 * e[3] + K9 * e[5] + K4 * e[7];
        o1  = K15 * e[1] - K4 * e[3] - K16 * e[5] - K9 * e[7];
        o2  = K9 * e[1] - K16 * e[3] + K4 * e[5] + K15 * e[7];
        o3  = K4 * e[1] - K9 * e[3] + K15 * e[5] - K16 * e[7];
        y[0] = OUT_W'((a0 + o0) >>> SHIFT);
        y[1] = OUT_W'((a1 + o1) >>> SHIFT);
        y[2] = OUT_W'((a2 + o2) >>> SHIFT);
        y[3] = OUT_W'((a3 + o3) >>> SHIFT);
        y[4] = OUT_W'((a3 - o3) >>> SHIFT);
        y[5] = OUT_W'((a2 - o2) >>> SHIFT);
        y[6] = OUT_W'((a1 - o1) >>> SHIFT);
        y[7] = OUT_W'((a0 - o0) >>> SHIFT);
    end
endmodule

// File: rtl/rr8x4_col4.sv
// Four-point inverse transform applied down one column.
module rr8x4_col4 #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 32,
    parameter int OUT_W = 16,
    parameter int RND   = 64,
    parameter int SHIFT = 7
) (
    input  logic signed [IN_W-1:0]  x [4],
    output logic signed [OUT_W-1:0] y [4]
);
    localparam logic signed [ACC_W-1:0] K10  = ACC_W'(10);
    localparam logic signed [ACC_W-1:0] K17  = ACC_W'(17);
    localparam logic signed [ACC_W-1:0] K22  = ACC_W'(22);
    localparam logic signed [ACC_W-1:0] RNDC = ACC_W'(RND);

    logic signed [ACC_W-1:0] e [4];

    for (genvar k = 0; k < 4; k++) begin : g_ext
        assign e[k] = ACC_W'(x[k]);
    end

    logic signed [ACC_W-1:0] p, q, u, v, w0, w1;

    always_comb begin
        p  = K17 * e[0] + RNDC;
        q  = K17 * e[2];
        u  = p + q;
        v  = p - q;
        w0 = K22 * e[1] + K10 * e[3];
        w1 = K10 * e[1] - K22 * e[3];
        y[0] = OUT_W'((u + w0) >>> SHIFT);
        y[1] = OUT_W'((v + w1) >>> SHIFT);
        y[2] = OUT_W'((v - w1) >>> SHIFT);
        y[3] = OUT_W'((u - w0) >>> SHIFT);
    end
endmodule

// File: rtl/rr8x4_pix_lane.sv
// One pixel lane: saturating signed add, then clamp to the pixel range.
module rr8x4_pix_lane #(
    parameter int RES_W = 16,
    parameter int PIX_W = 8
) (
    input  logic signed [RES_W-1:0] res,
    input  logic [PIX_W-1:0]        pred,
    output logic [PIX_W-1:0]        pix
);
    logic signed [RES_W:0]   wide;
    logic signed [RES_W-1:0] sat;

    always_comb begin
        wide = {res[RES_W-1], res} + {{(RES_W+1-PIX_W){1'b0}}, pred};
        if (wide[RES_W] != wide[RES_W-1]) begin
            sat = wide[RES_W] ? {1'b1, {(RES_W-1){1'b0}}}
                              : {1'b0, {(RES_W-1){1'b1}}};
        end else begin
            sat = wide[RES_W-1:0];
        end
        if (sat[RES_W-1]) begin
            pix = '0;
        end else if (|sat[RES_W-2:PIX_W]) begin
            pix = '1;
        end else begin
            pix = sat[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/rr8x4_recon.sv
module rr8x4_recon
    import rr8x4_pkg::*;
#(
    parameter int COEF_W  = 16,
    parameter int PIX_W   = 8,
    parameter int ACC_W   = 32,
    parameter int ROW_RND = 4,
    parameter int ROW_SH  = 3,
    parameter int COL_RND = 64,
    parameter int COL_SH  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    coef_valid,
    input  logic [COLS*COEF_W-1:0]  coef_row,
    output logic                    pix_en,
    output logic [ROW_IW-1:0]       pix_row,
    input  logic [COLS*PIX_W-1:0]   pred_pix,
    output logic [COLS*PIX_W-1:0]   recon_pix,
    output logic                    done
);
    localparam logic [CNT_W-1:0] LAST_ROW = CNT_W'(ROWS - 1);
    localparam logic [CNT_W-1:0] LAST_COL = CNT_W'(COLS - 1);

    rr_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    logic signed [COEF_W-1:0] buf_q   [ROWS][COLS];
    logic signed [COEF_W-1:0] coef_w  [COLS];
    logic signed [COEF_W-1:0] row_in  [COLS];
    logic signed [COEF_W-1:0] row_out [COLS];
    logic signed [COEF_W-1:0] col_in  [ROWS];
    logic signed [COEF_W-1:0] col_out [ROWS];
    logic signed [COEF_W-1:0] lane_res [COLS];
    logic [PIX_W-1:0]         lane_out [COLS];

    for (genvar k = 0; k < COLS; k++) begin : g_unpack
        assign coef_w[k] = coef_row[k*COEF_W +: COEF_W];
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_LOAD: begin
                if (coef_valid) begin
                    if (cnt_q == LAST_ROW) begin
                        state_d = ST_ROW;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_LOAD;
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
            end
            ST_ROW: begin
                if (cnt_q == LAST_ROW) begin
                    state_d = ST_COL;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_COL: begin
                if (cnt_q == LAST_COL) begin
                    state_d = ST_ADD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ADD: begin
                if (cnt_q == LAST_ROW) begin
                    state_d = ST_DONE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // ---------------- transform kernels ----------------
    always_comb begin
        for (int k = 0; k < COLS; k++) begin
            row_in[k]   = buf_q[cnt_q[ROW_IW-1:0]][k];
            lane_res[k] = buf_q[cnt_q[ROW_IW-1:0]][k];
        end
        for (int i = 0; i < ROWS; i++) begin
            col_in[i] = buf_q[i][cnt_q];
        end
    end

    rr8x4_row8 #(
        .IN_W (COEF_W), .ACC_W(ACC_W), .OUT_W(COEF_W),
        .RND  (ROW_RND), .SHIFT(ROW_SH)
    ) u_row (
        .x (row_in),
        .y (row_out)
    );

    rr8x4_col4 #(
        .IN_W (COEF_W), .ACC_W(ACC_W), .OUT_W(COEF_W),
        .RND  (COL_RND), .SHIFT(COL_SH)
    ) u_col (
        .x (col_in),
        .y (col_out)
    );

    // ---------------- in-place transpose buffer ----------------
    always_ff @(posedge clk) begin
        unique case (state_q)
            ST_IDLE, ST_LOAD: begin
                if (coef_valid) begin
                    for (int k = 0; k < COLS; k++) begin
                        buf_q[cnt_q[ROW_IW-1:0]][k] <= coef_w[k];
                    end
                end
            end
            ST_ROW: begin
                for (int k = 0; k < COLS; k++) begin
                    buf_q[cnt_q[ROW_IW-1:0]][k] <= row_out[k];
                end
            end
            ST_COL: begin
                for (int i = 0; i < ROWS; i++) begin
                    buf_q[i][cnt_q] <= col_out[i];
                end
            end
            ST_ADD, ST_DONE: ;
        endcase
    end

    // ---------------- pixel lanes ----------------
    for (genvar k = 0; k < COLS; k++) begin : g_lane
        rr8x4_pix_lane #(
            .RES_W (COEF_W),
            .PIX_W (PIX_W)
        ) u_lane (
            .res  (lane_res[k]),
            .pred (pred_pix[k*PIX_W +: PIX_W]),
            .pix  (lane_out[k])
        );

        // R5
        lane_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_en && !lane_res[k][COEF_W-1]) |-> (lane_out[k] >= pred_pix[k*PIX_W +: PIX_W]));
        // R5
        lane_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_en && lane_res[k][COEF_W-1]) |-> (lane_out[k] <= pred_pix[k*PIX_W +: PIX_W]));
    end

    // ---------------- outputs ----------------
    always_comb begin
        pix_en  = (state_q == ST_ADD);
        pix_row = cnt_q[ROW_IW-1:0];
        done    = (state_q == ST_DONE);
        for (int k = 0; k < COLS; k++) begin
            recon_pix[k*PIX_W +: PIX_W] = lane_out[k];
        end
    end

    // R6
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && $past(pix_en)) |-> (pix_row == $past(pix_row) + 1'b1));
    // R6
    first_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_en) |-> (pix_row == '0));
    // R7
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pix_en) |-> done);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROW || state_q == ST_COL || state_q == ST_ADD || state_q == ST_DONE)
        |=> (state_q != ST_LOAD));
endmodule

// File: tb/sim_rr8x4_recon.sv
`timescale 1ns/1ps
module sim_rr8x4_recon;
    localparam time CYC = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         coef_valid = 1'b0;
    logic [127:0] coef_row = '0;
    logic         pix_en;
    logic [1:0]   pix_row;
    logic [63:0]  pred_pix;
    logic [63:0]  recon_pix;
    logic         done;

    int cm [4][8];
    int pm [4][8];
    int em [4][8];
    int n_chk = 0;
    int n_bad = 0;

    always #(CYC/2) clk = ~clk;

    always_comb begin
        for (int k = 0; k < 8; k++) pred_pix[k*8 +: 8] = 8'(pm[pix_row][k]);
    end

    rr8x4_recon u0 (
        .clk (clk), .rst_n (rst_n), .coef_valid (coef_valid), .coef_row (coef_row),
        .pix_en (pix_en), .pix_row (pix_row), .pred_pix (pred_pix),
        .recon_pix (recon_pix), .done (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int t16(input int v);
        logic signed [15:0] h;
        h = v[15:0];
        return int'(h);
    endfunction

    function automatic int rnd16();
        logic signed [15:0] h;
        h = 16'($urandom);
        return int'(h);
    endfunction

    function automatic int rsmall(input int span);
        return int'($urandom % (2*span + 1)) - span;
    endfunction

    task automatic compute_ref();
        int mid [4][8];
        int s0, s1, s2, s3, s4, s5, s6, s7, a, b, c, d, e0, e1, e2, e3, o0, o1, o2, o3;
        int x0, x1, x2, x3, p, q, u, v, w0, w1, sum;
        int res [4];
        for (int r = 0; r < 4; r++) begin
            s0 = cm[r][0]; s1 = cm[r][1]; s2 = cm[r][2]; s3 = cm[r][3];
            s4 = cm[r][4]; s5 = cm[r][5]; s6 = cm[r][6]; s7 = cm[r][7];
            a = 12*(s0+s4) + 4; b = 12*(s0-s4) + 4;
            c = 16*s2 + 6*s6;   d = 6*s2 - 16*s6;
            e0 = a + c; e1 = b + d; e2 = b - d; e3 = a - c;
            o0 = 16*s1 + 15*s3 + 9*s5 + 4*s7;
            o1 = 15*s1 - 4*s3 - 16*s5 - 9*s7;
            o2 = 9*s1 - 16*s3 + 4*s5 + 15*s7;
            o3 = 4*s1 - 9*s3 + 15*s5 - 16*s7;
            mid[r][0] = t16((e0+o0) >>> 3); mid[r][7] = t16((e0-o0) >>> 3);
            mid[r][1] = t16((e1+o1) >>> 3); mid[r][6] = t16((e1-o1) >>> 3);
            mid[r][2] = t16((e2+o2) >>> 3); mid[r][5] = t16((e2-o2) >>> 3);
            mid[r][3] = t16((e3+o3) >>> 3); mid[r][4] = t16((e3-o3) >>> 3);
        end
        for (int k = 0; k < 8; k++) begin
            x0 = mid[0][k]; x1 = mid[1][k]; x2 = mid[2][k]; x3 = mid[3][k];
            p = 17*x0 + 64; q = 17*x2; u = p + q; v = p - q;
            w0 = 22*x1 + 10*x3; w1 = 10*x1 - 22*x3;
            res[0] = t16((u+w0) >>> 7); res[1] = t16((v+w1) >>> 7);
            res[2] = t16((v-w1) >>> 7); res[3] = t16((u-w0) >>> 7);
            for (int r = 0; r < 4; r++) begin
                sum = res[r] + pm[r][k];
                if (sum > 32767) sum = 32767;
                if (sum < -32768) sum = -32768;
                if (sum < 0) sum = 0;
                if (sum > 255) sum = 255;
                em[r][k] = sum;
            end
        end
    endtask

    // Loads one block, then follows it to completion and checks every output.
    task automatic run_block(input int gap, input bit noise, input string tag);
        int cyc = 0;
        int seen = 0;
        int last = 0;
        bit fin = 1'b0;
        compute_ref();
        for (int r = 0; r < 4; r++) begin
            repeat (gap) begin
                @(negedge clk);
                coef_valid = 1'b0;
                coef_row   = {$urandom, $urandom, $urandom, $urandom};
            end
            @(negedge clk);
            coef_valid = 1'b1;
            for (int k = 0; k < 8; k++) coef_row[k*16 +: 16] = 16'(cm[r][k]);
            @(posedge clk);
        end
        while (!fin && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (pix_en) begin
                chk(int'(pix_row) == seen, "R6 row order", int'(pix_row), seen);
                if (seen == 0) chk(cyc == 13, "R10 first row latency", cyc, 13);
                for (int k = 0; k < 8; k++)
                    chk(int'(recon_pix[k*8 +: 8]) == em[seen][k],
                        $sformatf("%s pixel r%0d c%0d", tag, seen, k),
                        int'(recon_pix[k*8 +: 8]), em[seen][k]);
                seen++;
                last = cyc;
            end
            if (done) begin
                chk(seen == 4, "R6 row count", seen, 4);
                chk(cyc == last + 1, "R7 done timing", cyc, last + 1);
                fin = 1'b1;
            end
            coef_valid = noise && !done;
            coef_row   = {$urandom, $urandom, $urandom, $urandom};
        end
        chk(fin, "R7 done seen", int'(fin), 1);
        @(negedge clk);
        chk(!done, "R7 single pulse", int'(done), 0);
        chk(!pix_en, "R6 no extra row", int'(pix_en), 0);
    endtask

    task automatic t_reset();
        chk(!pix_en, "R9 pix_en in reset", int'(pix_en), 0);
        chk(!done, "R9 done in reset", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!pix_en, "R9 pix_en after reset", int'(pix_en), 0);
        chk(!done, "R9 done after reset", int'(done), 0);
    endtask

    task automatic t_dc();
        foreach (cm[r, k]) cm[r][k] = 0;
        foreach (pm[r, k]) pm[r][k] = 100;
        cm[0][0] = 256;
        run_block(0, 1'b0, "R1 R3 dc");
    endtask

    task automatic t_odd();
        foreach (cm[r, k]) cm[r][k] = (k % 2 == 1) ? rsmall(600) : 0;
        foreach (pm[r, k]) pm[r][k] = 128;
        run_block(0, 1'b0, "R1 odd");
    endtask

    task automatic t_small();
        foreach (cm[r, k]) cm[r][k] = rsmall(80);
        foreach (pm[r, k]) pm[r][k] = int'($urandom % 256);
        run_block(0, 1'b0, "R4 add");
    endtask

    task automatic t_wide();
        for (int n = 0; n < 3; n++) begin
            foreach (cm[r, k]) cm[r][k] = rnd16();
            foreach (pm[r, k]) pm[r][k] = int'($urandom % 256);
            run_block(0, 1'b0, "R2 R3 wide");
        end
    endtask

    task automatic t_clamp();
        foreach (cm[r, k]) cm[r][k] = 0;
        foreach (pm[r, k]) pm[r][k] = 250;
        cm[0][0] = 4000;
        run_block(0, 1'b0, "R5 high");
        foreach (pm[r, k]) pm[r][k] = 5;
        cm[0][0] = -4000;
        run_block(0, 1'b0, "R5 low");
    endtask

    task automatic t_noise();
        foreach (cm[r, k]) cm[r][k] = rsmall(2000);
        foreach (pm[r, k]) pm[r][k] = int'($urandom % 256);
        run_block(0, 1'b1, "R8 busy loads");
        foreach (cm[r, k]) cm[r][k] = rsmall(2000);
        run_block(0, 1'b0, "R8 next block");
    endtask

    task automatic t_gap();
        foreach (cm[r, k]) cm[r][k] = rsmall(3000);
        foreach (pm[r, k]) pm[r][k] = int'($urandom % 256);
        run_block(3, 1'b0, "R10 gapped");
    endtask

    initial begin
        #(CYC * 150000);
        n_bad++;
        $display("FAIL R7 watchdog: got %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        foreach (pm[r, k]) pm[r][k] = 0;
        foreach (cm[r, k]) cm[r][k] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        t_dc();
        t_odd();
        t_small();
        t_wide();
        t_clamp();
        t_noise();
        t_gap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule